// File: doc/BRIEF.md
# Slave Port Round-Robin Arbiter

This block decides which of several bus masters is connected to one slave port of a multi-master interconnect. Each master raises its request line for as long as it wants the slave. A master that holds the grant keeps it until its request drops. The block drives a one-hot grant vector, a connected flag and the index of the connected master, which the slave-side multiplexer uses.

Two configurable rules shape the grant. The first is a slot limit. A cycle counter restarts at every arbitration, and when it reaches the programmed limit a fresh round-robin arbitration runs. That arbitration breaks a long burst if another master is waiting. A limit of zero switches the rule off. The second rule is a parking policy for idle periods. The slave can be left unconnected, left on the master that used it last, or moved to one fixed master. A master the slave is parked on gets its grant in the same cycle it asks. In the unconnected case every new access pays one extra cycle.

A single 32-bit configuration word holds the slot limit, the parking policy and the fixed master number. A write-protect input blocks writes to it.

Top module: `slave_port_arbiter`

## Requirements
- R1: After reset the grant vector is zero, `grant_valid` is low, and `cfg_rdata` reads 0x000001FF: a slot limit of 511, parking policy 0 and fixed master 0.
- R2: With `wp_en` low, a write on `cfg_we` loads `cfg_wdata` and is visible on `cfg_rdata` one cycle later. The slot limit is in bits [8:0], the parking policy in bits [17:16] and the fixed master number in bits [20:18]. All other bits read as zero.
- R3: With `wp_en` high, a write leaves `cfg_rdata` and the arbitration behaviour unchanged.
- R4: `grant` is zero or one-hot. When `grant_valid` is high, the set bit is at position `grant_idx`. When it is low, `grant` is zero.
- R5: When several masters request at an arbitration, the grant goes to the first requester found by searching upward from the index after the last granted master, wrapping past the top index.
- R6: A granted master keeps the grant for as long as its request stays high, unless the slot limit expires. When its request drops, arbitration runs at the next edge.
- R7: With a nonzero slot limit L and another master requesting, the current master holds the grant for exactly L+1 cycles counted from its arbitration. The grant then passes on.
- R8: When the slot limit expires and no other master is requesting, the current master keeps the grant.
- R9: Parking policy 0 (none): with no request pending the slave is disconnected. A master requesting an unconnected slave is granted one cycle after its request is first sampled.
- R10: Parking policy 1 (last): with no request pending the slave stays connected to the master granted last. That master has the grant in the same cycle it raises its request again.
- R11: Parking policy 2 (fixed): with no request pending the slave connects to the master numbered in the fixed field. That master has the grant in the same cycle it raises its request.
- R12: Parking policy encoding 3 behaves exactly like policy 0.
- R13: Under policy 2, a fixed master number not below the master count behaves like policy 0.
- R14: Under policies 0 and 3, a master whose request has dropped does not keep the grant past the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | N_MASTERS | Request line per master, held high for the length of an access or burst |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| wp_en | input | 1 | Write-protect enable; blocks configuration writes while high |
| cfg_rdata | output | 32 | Current configuration word |
| grant | output | N_MASTERS | One-hot grant to the masters |
| grant_valid | output | 1 | Slave is connected to a master |
| grant_idx | output | $clog2(N_MASTERS) | Index of the connected master |

## Verification
The bench builds the arbiter with four masters rather than the default eight. With four masters the round-robin wrap from index 3 back to 0 takes only a short burst of traffic. It also means fixed master numbers 4 to 7 fit in the 3-bit field while pointing at no real master, so the fallback of an out-of-range parking target can be reached. A slot limit of 3 makes burst breaking and the L+1 holding window show up within a dozen cycles, and the full 9-bit limit field is still exercised through reset readback.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int SLOT_W     = 9;
  localparam int MODE_LSB   = 16;
  localparam int FIXED_LSB  = 18;
  localparam int FIXED_W    = 3;
  localparam int CFG_W      = 32;

  localparam logic [CFG_W-1:0] CFG_MASK  =
    (((CFG_W'(1) << FIXED_W) - 1) << FIXED_LSB) |
    (CFG_W'(3) << MODE_LSB) |
    ((CFG_W'(1) << SLOT_W) - 1);

  localparam logic [CFG_W-1:0] CFG_RESET = (CFG_W'(1) << SLOT_W) - 1;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_NONE3 = 2'd3
  } park_mode_e;

  typedef struct packed {
    logic [FIXED_W-1:0] fixed_master;
    park_mode_e         mode;
    logic [SLOT_W-1:0]  slot_limit;
  } arb_cfg_t;

endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             wp_en,
  output arb_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata
);

  logic [CFG_W-1:0] word_q;
  logic [CFG_W-1:0] word_d;
  logic             word_en;

  assign word_en = we && !wp_en;
  assign word_d  = wdata & CFG_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= CFG_RESET;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign rdata             = word_q;
  assign cfg.slot_limit    = word_q[SLOT_W-1:0];
  assign cfg.mode          = park_mode_e'(word_q[MODE_LSB +: 2]);
  assign cfg.fixed_master  = word_q[FIXED_LSB +: FIXED_W];

endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (limit != '0) && (cnt_q == limit);

endmodule

// File: rtl/arb_rr_picker.sv
module arb_rr_picker #(
  parameter int N_MASTERS = 8,
  parameter int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [N_MASTERS-1:0] cand,
  input  logic [IDX_W-1:0]     last_idx,
  output logic                 pick_valid,
  output logic [IDX_W-1:0]     pick_idx
);

  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = last_idx;
    for (int k = 1; k <= N_MASTERS; k++) begin
      int unsigned pos;
      pos = (int'(last_idx) + k) % N_MASTERS;
      if (!pick_valid && cand[pos]) begin
        pick_valid = 1'b1;
        pick_idx   = IDX_W'(pos);
      end
    end
  end

endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 8,
  parameter int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 wp_en,
  output logic [CFG_W-1:0]     cfg_rdata,
  output logic [N_MASTERS-1:0] grant,
  output logic                 grant_valid,
  output logic [IDX_W-1:0]     grant_idx
);

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  arb_cfg_t cfg;

  arb_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .wp_en (wp_en),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  logic             conn_q,  conn_d;
  logic [IDX_W-1:0] owner_q, owner_d;
  logic             arb_now;
  logic             slot_expired;
  logic             pick_valid;
  logic [IDX_W-1:0] pick_idx;
  logic             fixed_ok;

  arb_slot_timer #(.CNT_W(SLOT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (arb_now),
    .limit   (cfg.slot_limit),
    .expired (slot_expired)
  );

  arb_rr_picker #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick (
    .cand       (req),
    .last_idx   (owner_q),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  assign fixed_ok = int'(cfg.fixed_master) < N_MASTERS;

  // arbitrate when unconnected, when the owner's access ended, or on slot expiry
  assign arb_now = !conn_q || !req[owner_q] || slot_expired;

  always_comb begin
    conn_d  = conn_q;
    owner_d = owner_q;
    if (arb_now) begin
      if (pick_valid) begin
        conn_d  = 1'b1;
        owner_d = pick_idx;
      end else begin
        unique case (cfg.mode)
          PARK_LAST: begin
            conn_d  = conn_q;
            owner_d = owner_q;
          end
          PARK_FIXED: begin
            if (fixed_ok) begin
              conn_d  = 1'b1;
              owner_d = IDX_W'(cfg.fixed_master);
            end else begin
              conn_d  = 1'b0;
            end
          end
          default: begin
            conn_d  = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      conn_q  <= 1'b0;
      owner_q <= '0;
    end else if (arb_now) begin
      conn_q  <= conn_d;
      owner_q <= owner_d;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_MASTERS; gi++) begin : g_grant
      assign grant[gi] = conn_q && (owner_q == IDX_W'(gi));
    end
  endgenerate

  assign grant_valid = conn_q;
  assign grant_idx   = owner_q;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N_MASTERS = 8,
  parameter int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req,
  input logic [31:0]          cfg_rdata,
  input logic [N_MASTERS-1:0] grant,
  input logic                 grant_valid,
  input logic [IDX_W-1:0]     grant_idx
);

  logic [1:0] mode;
  logic [2:0] fixed_m;
  logic       park_none;

  assign mode      = cfg_rdata[17:16];
  assign fixed_m   = cfg_rdata[20:18];
  assign park_none = (mode == 2'd0) || (mode == 2'd3);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("grant not one-hot"); // R4

  AST_GRANT_MATCHES_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant[grant_idx]) else $error("grant bit off index"); // R4

  AST_NO_GRANT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant == '0)) else $error("grant while unconnected"); // R4

  AST_HOLD_UNLIMITED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && req[grant_idx] && cfg_rdata[8:0] == 9'd0)
      |=> (grant_valid && grant_idx == $past(grant_idx))) else $error("burst broken"); // R6

  AST_NONE_DISCONNECT: assert property (@(posedge clk) disable iff (!rst_n)
    (park_none && req == '0) |=> !grant_valid) else $error("parked under none"); // R9

  AST_LAST_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && req == '0 && grant_valid)
      |=> (grant_valid && grant_idx == $past(grant_idx))) else $error("left last master"); // R10

  AST_FIXED_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && int'(fixed_m) < N_MASTERS && req == '0)
      |=> (grant_valid && int'(grant_idx) == int'($past(fixed_m)))) else $error("not on fixed"); // R11

  AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (park_none && grant_valid && !req[grant_idx])
      |=> (!grant_valid || grant_idx != $past(grant_idx))) else $error("idle master kept grant"); // R14

endmodule

bind slave_port_arbiter arb_checker #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_arb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .cfg_rdata   (cfg_rdata),
  .grant       (grant),
  .grant_valid (grant_valid),
  .grant_idx   (grant_idx)
);

// File: tb/slave_port_arbiter_test.sv
`timescale 1ns/1ps
module slave_port_arbiter_test;

  localparam int N     = 4;
  localparam int IW    = 2;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          cfg_we;
  logic [31:0]   cfg_wdata;
  logic          wp_en;
  logic [31:0]   cfg_rdata;
  logic [N-1:0]  grant;
  logic          grant_valid;
  logic [IW-1:0] grant_idx;

  slave_port_arbiter #(.N_MASTERS(N)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .wp_en(wp_en), .cfg_rdata(cfg_rdata),
    .grant(grant), .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    int          at;
    bit          is_cfg;
    bit          valid;
    int          idx;
    logic [31:0] word;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc    = 0;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  function automatic logic [31:0] pack(int slot, int mode, int fixed_m);
    return (32'(fixed_m) << 18) | (32'(mode) << 16) | 32'(slot);
  endfunction

  task automatic cmp_grant(bit ev, int ei, string tag);
    logic [N-1:0] eg;
    eg = ev ? (N'(1) << ei) : '0;
    checks++;
    if (grant_valid !== ev || (ev && int'(grant_idx) != ei)) begin
      fails++;
      $display("FAIL %s: valid/idx %0b/%0d expected %0b/%0d", tag, grant_valid, grant_idx, ev, ei);
    end
    checks++;
    if (grant !== eg) begin  // R4 vector shape
      fails++;
      $display("FAIL R4 (%s): grant %b expected %b", tag, grant, eg);
    end
  endtask

  task automatic cmp_cfg(logic [31:0] ew, string tag);
    checks++;
    if (cfg_rdata !== ew) begin
      fails++;
      $display("FAIL %s: cfg_rdata %h expected %h", tag, cfg_rdata, ew);
    end
  endtask

  // scoreboard driver side
  task automatic exp_grant(int n, bit v, int i, string tag);
    exp_t e;
    e.at = cyc + n; e.is_cfg = 0; e.valid = v; e.idx = i; e.word = '0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic exp_cfg(int n, logic [31:0] w, string tag);
    exp_t e;
    e.at = cyc + n; e.is_cfg = 1; e.valid = 0; e.idx = 0; e.word = w; e.tag = tag;
    q.push_back(e);
  endtask

  // scoreboard monitor side
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].at <= cyc) begin
          if (q[i].is_cfg) cmp_cfg(q[i].word, q[i].tag);
          else             cmp_grant(q[i].valid, q[i].idx, q[i].tag);
          q.delete(i);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d, logic [31:0] ew, string tag);
    cfg_we = 1'b1; cfg_wdata = d;
    exp_cfg(1, ew, tag);
    tick(1);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end

  initial begin
    req = '0; cfg_we = 1'b0; cfg_wdata = '0; wp_en = 1'b0; rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    cmp_grant(0, 0, "R1 reset grant");
    cmp_cfg(32'h0000_01FF, "R1 reset config");

    // R2 write, slot limit off, policy none
    wr(pack(0, 0, 0), pack(0, 0, 0), "R2 write");

    // R9 one-cycle penalty from unconnected
    req = 4'b0001;
    cmp_grant(0, 0, "R9 penalty cycle");
    exp_grant(1, 1, 0, "R9 granted after one cycle");
    tick(1);
    // R6 hold while requesting, another waiting
    req = 4'b0011;
    for (int k = 1; k <= 4; k++) exp_grant(k, 1, 0, "R6 hold");
    tick(4);
    req = 4'b0010;
    exp_grant(1, 1, 1, "R6 handoff at end of access");
    tick(1);
    req = 4'b0000;
    exp_grant(1, 0, 0, "R9 idle disconnect");
    tick(2);

    // R5 round robin, last granted = 1
    req = 4'b1111; exp_grant(1, 1, 2, "R5 after last"); tick(1);
    req = 4'b1011; exp_grant(1, 1, 3, "R5 next");       tick(1);
    req = 4'b0011; exp_grant(1, 1, 0, "R5 wrap");       tick(1);
    req = 4'b0000; exp_grant(1, 0, 0, "R14 release");   tick(1);

    // R7 slot limit 3 breaks bursts
    wr(pack(3, 0, 0), pack(3, 0, 0), "R2 slot write");
    req = 4'b0001; exp_grant(1, 1, 0, "R7 start"); tick(1);
    req = 4'b0011;
    exp_grant(1, 1, 0, "R7 hold"); exp_grant(2, 1, 0, "R7 hold");
    exp_grant(3, 1, 0, "R7 last slot cycle");
    exp_grant(4, 1, 1, "R7 broken after L+1");
    exp_grant(7, 1, 1, "R7 second holder");
    exp_grant(8, 1, 0, "R7 broken back");
    tick(8);
    req = 4'b0000; exp_grant(1, 0, 0, "R14 release"); tick(1);

    // R8 expiry with nobody else waiting
    req = 4'b0001; exp_grant(1, 1, 0, "R8 start"); tick(1);
    exp_grant(4, 1, 0, "R8 keep"); exp_grant(6, 1, 0, "R8 keep");
    exp_grant(9, 1, 0, "R8 keep");
    tick(9);
    req = 4'b0000; exp_grant(1, 0, 0, "R9 idle"); tick(1);

    // R10 park on last
    wr(pack(0, 1, 0), pack(0, 1, 0), "R2 last write");
    req = 4'b0100; exp_grant(1, 1, 2, "R10 grant"); tick(1);
    req = 4'b0000;
    exp_grant(1, 1, 2, "R10 parked"); exp_grant(3, 1, 2, "R10 parked");
    tick(3);
    req = 4'b0100;
    cmp_grant(1, 2, "R10 zero latency");
    exp_grant(1, 1, 2, "R10 hold"); tick(1);
    req = 4'b0010; exp_grant(1, 1, 1, "R10 other master"); tick(1);
    req = 4'b0000; tick(1);

    // R11 park on fixed master 3
    wr(pack(0, 2, 3), pack(0, 2, 3), "R2 fixed write");
    exp_grant(1, 1, 3, "R11 parked on fixed"); tick(1);
    req = 4'b1000;
    cmp_grant(1, 3, "R11 zero latency"); tick(1);
    req = 4'b0001; exp_grant(1, 1, 0, "R11 other master"); tick(1);
    req = 4'b0000; exp_grant(1, 1, 3, "R11 back to fixed"); tick(1);

    // R12 encoding 3 acts as none
    wr(pack(0, 3, 3), pack(0, 3, 3), "R2 mode3 write");
    exp_grant(1, 0, 0, "R12 disconnect"); tick(1);
    req = 4'b0001;
    cmp_grant(0, 0, "R12 penalty cycle");
    exp_grant(1, 1, 0, "R12 granted"); tick(1);
    req = 4'b0000; exp_grant(1, 0, 0, "R12 idle"); tick(1);

    // R13 out-of-range fixed master
    wr(pack(0, 2, 5), pack(0, 2, 5), "R2 fixed5 write");
    exp_grant(1, 0, 0, "R13 no park"); exp_grant(2, 0, 0, "R13 no park");
    tick(2);

    // R3 write protect
    wp_en = 1'b1;
    wr(pack(7, 1, 1), pack(0, 2, 5), "R3 protected write");
    req = 4'b0010; exp_grant(1, 1, 1, "R3 grant"); tick(1);
    req = 4'b0000; exp_grant(1, 0, 0, "R3 policy unchanged"); tick(1);
    wp_en = 1'b0;

    tick(3);
    done = 1;
    summary();
  end

endmodule